// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out the following program counter for a small 8-bit core whose instructions are 16-bit words. The decoder gives it one control-flow kind per instruction: a plain step to the next word, a relative branch that fires only when a flag condition holds, an unconditional relative jump, a two-word absolute jump, or a call through a 16-bit pointer. From these it computes the next PC, whether the flow was redirected, and how many cycles the instruction costs.

The current PC, the decoded fields, the four status flags and the pointer are sampled on each rising clock edge. The three results are registered, so they appear one cycle after the inputs that produced them. Relative targets are the address of the following word plus a sign-extended offset. All PC arithmetic wraps within the PC width.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc`, `taken` and `cycles` are all zero. The clear is asynchronous.
- R2: For kind 0 (step), `next_pc` = `pc`+1, `taken` = 0 and `cycles` = 1.
- R3: For kind 1 (conditional branch), when the condition holds, `next_pc` = `pc`+1+`br_off`, with `br_off` read as a signed 7-bit value (−64..+63). Otherwise `next_pc` = `pc`+1.
- R4: The raw condition is chosen by `br_sel`: 0 tests Z, 1 tests C, 2 tests N XOR V, 3 tests N. The branch fires when the raw condition XOR `br_inv` is 1. So "equal" is sel 0 with inv 0, "not equal" is sel 0 with inv 1, "lower" is sel 1 with inv 0, "signed greater or equal" is sel 2 with inv 1, and "signed less than" is sel 2 with inv 0.
- R5: A conditional branch reports `taken` = 1 and `cycles` = 2 when it fires, and `taken` = 0 and `cycles` = 1 when it does not.
- R6: For kind 2 (relative jump), `next_pc` = `pc`+1+`rj_off`, with `rj_off` read as a signed 12-bit value (−2048..2047). It reports `taken` = 1 and `cycles` = 2.
- R7: For kind 3 (absolute jump), `next_pc` = `abs_tgt`, `taken` = 1 and `cycles` = 3.
- R8: For kind 4 (pointer call), `next_pc` bits 15:0 equal `zptr` and bits 21:16 are zero. It reports `taken` = 1 and `cycles` = 3.
- R9: Kinds 5, 6 and 7 behave exactly like kind 0, whatever the branch fields and flags are.
- R10: The outputs change only on a rising clock edge. They reflect the inputs present at that edge.
- R11: All PC arithmetic wraps modulo 2^22. A step from 0x3FFFFF gives 0. A backward branch below address 0 wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Control-flow kind (0 step, 1 branch, 2 rel jump, 3 abs jump, 4 pointer call) |
| pc | input | 22 | Current program counter |
| br_off | input | 7 | Signed branch offset |
| br_sel | input | 2 | Branch condition selector |
| br_inv | input | 1 | Inverts the branch condition |
| rj_off | input | 12 | Signed relative jump offset |
| abs_tgt | input | 22 | Absolute jump target |
| zptr | input | 16 | Pointer for the indirect call |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Two's complement overflow flag |
| next_pc | output | 22 | Registered next program counter |
| taken | output | 1 | Registered redirect indication |
| cycles | output | 2 | Registered cycle cost |

## Verification
The bench builds the block with its default widths: a 22-bit PC, a 7-bit branch offset, a 12-bit jump offset and a 16-bit pointer. With the full 22-bit PC it can reach the top-of-space wrap and the zeroing of bits 21:16 on a pointer call. The two offset widths let it drive the most negative and most positive offsets of each kind. All five condition encodings are covered, including the signed pair, where N and V are both set.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int PC_W  = 22,
  parameter int BR_W  = 7,
  parameter int RJ_W  = 12,
  parameter int PTR_W = 16,
  parameter int CYC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [PC_W-1:0]  pc,
  input  logic [BR_W-1:0]  br_off,
  input  logic [1:0]       br_sel,
  input  logic             br_inv,
  input  logic [RJ_W-1:0]  rj_off,
  input  logic [PC_W-1:0]  abs_tgt,
  input  logic [PTR_W-1:0] zptr,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic             flag_v,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic [CYC_W-1:0] cycles
);
  localparam logic [2:0] K_STEP = 3'd0;
  localparam logic [2:0] K_BR   = 3'd1;
  localparam logic [2:0] K_RJ   = 3'd2;
  localparam logic [2:0] K_ABS  = 3'd3;
  localparam logic [2:0] K_PTR  = 3'd4;

  logic [PC_W-1:0] pc_inc, br_dst, rj_dst, ptr_dst;
  logic [PC_W-1:0] npc_d;
  logic            raw_cond, fire, tk_d;
  logic [CYC_W-1:0] cy_d;

  assign pc_inc  = pc + 1'b1;
  assign br_dst  = pc_inc + {{(PC_W-BR_W){br_off[BR_W-1]}}, br_off};
  assign rj_dst  = pc_inc + {{(PC_W-RJ_W){rj_off[RJ_W-1]}}, rj_off};
  assign ptr_dst = {{(PC_W-PTR_W){1'b0}}, zptr};

  always_comb begin
    case (br_sel)
      2'd0:    raw_cond = flag_z;
      2'd1:    raw_cond = flag_c;
      2'd2:    raw_cond = flag_n ^ flag_v;
      default: raw_cond = flag_n;
    endcase
  end

  assign fire = raw_cond ^ br_inv;

  always_comb begin
    npc_d = pc_inc;
    tk_d  = 1'b0;
    cy_d  = CYC_W'(1);
    case (op)
      K_BR: begin
        npc_d = fire ? br_dst : pc_inc;
        tk_d  = fire;
        cy_d  = fire ? CYC_W'(2) : CYC_W'(1);
      end
      K_RJ: begin
        npc_d = rj_dst;
        tk_d  = 1'b1;
        cy_d  = CYC_W'(2);
      end
      K_ABS: begin
        npc_d = abs_tgt;
        tk_d  = 1'b1;
        cy_d  = CYC_W'(3);
      end
      K_PTR: begin
        npc_d = ptr_dst;
        tk_d  = 1'b1;
        cy_d  = CYC_W'(3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc <= '0;
      taken   <= 1'b0;
      cycles  <= '0;
    end else begin
      next_pc <= npc_d;
      taken   <= tk_d;
      cycles  <= cy_d;
    end
  end
endmodule

module pc_next_unit_chk #(
  parameter int PC_W  = 22,
  parameter int PTR_W = 16,
  parameter int CYC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  abs_tgt,
  input logic [PTR_W-1:0] zptr,
  input logic [PC_W-1:0]  next_pc,
  input logic             taken,
  input logic [CYC_W-1:0] cycles
);
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == 3'd0) |->
      (next_pc == PC_W'($past(pc) + 1'b1) && !taken && cycles == CYC_W'(1)));

  // R5
  branch_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == 3'd1) |->
      (taken ? cycles == CYC_W'(2) : cycles == CYC_W'(1)));

  // R6
  rjump_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == 3'd2) |-> (taken && cycles == CYC_W'(2)));

  // R7
  abs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == 3'd3) |->
      (next_pc == $past(abs_tgt) && taken && cycles == CYC_W'(3)));

  // R8
  ptr_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == 3'd4) |->
      (next_pc[PC_W-1:PTR_W] == '0 && next_pc[PTR_W-1:0] == $past(zptr) &&
       taken && cycles == CYC_W'(3)));

  // R9
  spare_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) > 3'd4) |->
      (next_pc == PC_W'($past(pc) + 1'b1) && !taken && cycles == CYC_W'(1)));
endmodule

bind pc_next_unit pc_next_unit_chk #(.PC_W(PC_W), .PTR_W(PTR_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .pc(pc), .abs_tgt(abs_tgt), .zptr(zptr),
  .next_pc(next_pc), .taken(taken), .cycles(cycles)
);

// File: tb/pc_next_unit_tb.sv
module pc_next_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [21:0] pc = '0;
  logic [6:0]  br_off = '0;
  logic [1:0]  br_sel = '0;
  logic        br_inv = 1'b0;
  logic [11:0] rj_off = '0;
  logic [21:0] abs_tgt = '0;
  logic [15:0] zptr = '0;
  logic        flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
  logic [21:0] next_pc;
  logic        taken;
  logic [1:0]  cycles;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pc_next_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .pc(pc), .br_off(br_off), .br_sel(br_sel),
    .br_inv(br_inv), .rj_off(rj_off), .abs_tgt(abs_tgt), .zptr(zptr),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .next_pc(next_pc), .taken(taken), .cycles(cycles)
  );

  // op | pc | br_off | sel | inv | rj_off | abs | zptr | {c,z,n,v} | exp pc | exp taken | exp cycles
  localparam int NV = 17;
  localparam logic [113:0] VEC [NV] = '{
    {3'd0, 22'h000010, 7'h00, 2'd0, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0000, 22'h000011, 1'b0, 2'd1}, // R2
    {3'd0, 22'h3FFFFF, 7'h00, 2'd0, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0000, 22'h000000, 1'b0, 2'd1}, // R11
    {3'd1, 22'h000100, 7'h05, 2'd0, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0100, 22'h000106, 1'b1, 2'd2}, // R3 R4 R5
    {3'd1, 22'h000100, 7'h05, 2'd0, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0000, 22'h000101, 1'b0, 2'd1}, // R3 R5
    {3'd1, 22'h000100, 7'h40, 2'd0, 1'b1, 12'h000, 22'h0, 16'h0, 4'b0000, 22'h0000C1, 1'b1, 2'd2}, // R3 R4
    {3'd1, 22'h000200, 7'h3F, 2'd1, 1'b0, 12'h000, 22'h0, 16'h0, 4'b1000, 22'h000240, 1'b1, 2'd2}, // R3 R4
    {3'd1, 22'h000050, 7'h7F, 2'd2, 1'b1, 12'h000, 22'h0, 16'h0, 4'b0011, 22'h000050, 1'b1, 2'd2}, // R4
    {3'd1, 22'h000050, 7'h7F, 2'd2, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0011, 22'h000051, 1'b0, 2'd1}, // R4
    {3'd1, 22'h000000, 7'h02, 2'd3, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0010, 22'h000003, 1'b1, 2'd2}, // R4
    {3'd1, 22'h000010, 7'h40, 2'd0, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0100, 22'h3FFFD1, 1'b1, 2'd2}, // R11
    {3'd1, 22'h000200, 7'h3F, 2'd1, 1'b1, 12'h000, 22'h0, 16'h0, 4'b1000, 22'h000201, 1'b0, 2'd1}, // R4 R5
    {3'd2, 22'h001000, 7'h00, 2'd0, 1'b0, 12'h7FF, 22'h0, 16'h0, 4'b0000, 22'h001800, 1'b1, 2'd2}, // R6
    {3'd2, 22'h001000, 7'h00, 2'd0, 1'b0, 12'h800, 22'h0, 16'h0, 4'b0000, 22'h000801, 1'b1, 2'd2}, // R6
    {3'd3, 22'h000123, 7'h00, 2'd0, 1'b0, 12'h000, 22'h3ABCDE, 16'h0, 4'b0000, 22'h3ABCDE, 1'b1, 2'd3}, // R7
    {3'd4, 22'h3F0000, 7'h00, 2'd0, 1'b0, 12'h000, 22'h0, 16'hBEEF, 4'b0000, 22'h00BEEF, 1'b1, 2'd3}, // R8
    {3'd7, 22'h000020, 7'h05, 2'd0, 1'b0, 12'h000, 22'h0, 16'h0, 4'b0100, 22'h000021, 1'b0, 2'd1}, // R9
    {3'd5, 22'h3FFFFF, 7'h05, 2'd0, 1'b0, 12'h7FF, 22'h0, 16'h0, 4'b1111, 22'h000000, 1'b0, 2'd1}  // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [113:0] v);
    op      = v[113:111];
    pc      = v[110:89];
    br_off  = v[88:82];
    br_sel  = v[81:80];
    br_inv  = v[79];
    rj_off  = v[78:67];
    abs_tgt = v[66:45];
    zptr    = v[44:29];
    {flag_c, flag_z, flag_n, flag_v} = v[28:25];
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(VEC[0]);
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset next_pc", 32'(next_pc), 32'h0);
    check("R1 reset taken", 32'(taken), 32'h0);
    check("R1 reset cycles", 32'(cycles), 32'h0);

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 no change before edge", 32'(next_pc), 32'h0);
    @(posedge clk);
    #1;
    check("R10 updated at edge", 32'(next_pc), 32'h000011);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("table row %0d next_pc", i), 32'(next_pc), 32'(VEC[i][24:3]));
      check($sformatf("table row %0d taken", i), 32'(taken), 32'(VEC[i][2]));
      check($sformatf("table row %0d cycles", i), 32'(cycles), 32'(VEC[i][1:0]));
    end

    @(negedge clk);
    drive(VEC[13]);
    #1;
    check("R10 held between edges", 32'(next_pc), 32'h000000);
    rst_n = 1'b0;
    #1;
    check("R1 async clear taken", 32'(taken), 32'h0);
    check("R1 async clear cycles", 32'(cycles), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R7 after reset", 32'(next_pc), 32'h3ABCDE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule